// File: doc/BRIEF.md
# Event-Triggered DMA Channel Sequencer

This block is the control half of a multi-channel DMA engine. Sixteen hardware sync inputs, one per channel, are edge-detected into a pending register. A fixed-priority picker chooses one pending channel. The sequencer then reads that channel's six-word parameter entry from a local 2 KB parameter RAM and issues one transfer request over a valid/ready port. It waits for the data mover to report completion, then advances the counts and addresses. At the end of a block it can replace the channel's entry with a linked entry held elsewhere in the RAM. Because of this, a ping-pong double buffer keeps running without CPU involvement.

Completion raises a pending bit chosen by a 4-bit completion code, so several channels can share one bit. A single interrupt line is the OR of the pending bits that are also enabled. The CPU fills the parameter RAM through a word-wide port and reads it back through the same port. A small register port clears the event, missed-event and interrupt flags by write-one-to-clear and sets the interrupt enables.

The sequencer walks these named states:
- `S_IDLE` → `S_FETCH` when a channel is pending.
- `S_FETCH` → `S_ISSUE` after six words, or back to `S_IDLE` if the element count is zero.
- `S_ISSUE` → `S_WAIT` on ready.
- `S_WAIT` → `S_CALC` on transfer done.
- `S_CALC` → `S_LFETCH` when a valid link is taken, otherwise → `S_WRBK`.
- `S_LFETCH` → `S_WRBK` after six words.
- `S_WRBK` → `S_IDLE` after six words.

Top module: `dma_evt_seq`

## Requirements
- R1: A rising edge on `evt_in[c]` sets `evt_pend[c]`. The bit clears when channel c is picked, or when the CPU writes 1 to it through register select 0. A channel cleared this way is never serviced.
- R2: A rising edge on a channel whose pending bit is already set, and not being cleared in that cycle, sets `evt_miss[c]`. Writing 1 through register select 1 clears it.
- R3: When several channels are pending, the lowest channel number is serviced first.
- R4: The entry of channel c starts at word 6·c and is laid out as follows:
  - word 0: options
  - word 1: source address
  - word 2: frame count [31:16] and element count [15:0]
  - word 3: destination address
  - word 4: frame index [31:16] and element index [15:0]
  - word 5: element-count reload [31:16] and link byte address [15:0]

  The request carries word 1 on `tr_src`, word 3 on `tr_dst` and the options word on `tr_opt`.
- R5: The options fields used by the sequencer are:
  - priority [31:29]
  - element size [28:27]: 0 byte, 1 half, 2 or 3 word
  - source mode [25:24] and destination mode [22:21]: 0 fixed, 1 step by the element size, 2 step back by it, 3 add the signed index
  - interrupt enable [20]
  - code [19:16]
  - link enable [1]
  - frame sync [0]
- R6: With frame sync 0, each event issues `tr_cnt`=1. After each element the element count drops by one and the address uses the element step. After the last element of a frame, indexed mode adds the frame index instead, the element count reloads and the frame count drops by one.
- R7: With frame sync 1, each event issues `tr_cnt` equal to the element count. Afterwards a stepping address moves by count×size, an indexed address adds the frame index, the element count reloads and the frame count drops by one.
- R8: A block ends when the last frame (frame count 0) completes. Both counts are then written back as zero. A later event on that channel issues no request.
- R9: When a block ends with link enable set, the six words at the link address overwrite the channel's entry, so two entries that link to each other alternate.
- R10: A link address that is not a multiple of 24, or whose entry would pass the RAM end, suppresses the copy and sets the sticky `link_err`.
- R11: At block end with interrupt enable set, `int_pend[code]` is set. This happens only after `xfer_done`, never when the request is accepted.
- R12: `irq` is high while any `int_pend` bit has its `int_en` bit set. Register select 2 clears pending bits by write-one, and select 3 loads `int_en`.
- R13: While `tr_valid` is high and `tr_ready` is low, the request fields hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_in | input | 16 | Per-channel sync event inputs |
| cpu_we | input | 1 | Parameter RAM write strobe |
| cpu_addr | input | 9 | Parameter RAM word address |
| cpu_wdata | input | 32 | Parameter RAM write data |
| cpu_rdata | output | 32 | Parameter RAM read data (combinational) |
| cpu_reg_we | input | 1 | Control register write strobe |
| cpu_reg_sel | input | 2 | 0 event clear, 1 missed clear, 2 interrupt clear, 3 interrupt enable |
| cpu_reg_wdata | input | 16 | Control register write data |
| evt_pend | output | 16 | Latched events |
| evt_miss | output | 16 | Missed-event flags |
| int_pend | output | 16 | Interrupt pending bits by completion code |
| int_en | output | 16 | Interrupt enable bits |
| irq | output | 1 | Shared interrupt |
| link_err | output | 1 | Sticky bad-link flag |
| tr_valid | output | 1 | Transfer request valid |
| tr_ready | input | 1 | Transfer request accepted |
| tr_ch | output | 4 | Requesting channel |
| tr_opt | output | 32 | Options word of the request |
| tr_src | output | 32 | Source address |
| tr_dst | output | 32 | Destination address |
| tr_cnt | output | 16 | Elements in this request |
| xfer_done | input | 1 | Data mover reports the accepted request finished |

## Verification
A wrong count or address in the parameter entry does not appear at once. It shows up one event later as a wrong `tr_src`, `tr_dst` or `tr_cnt`, or straight away when the entry is read back once the sequencer is idle. A wrong frame-end decision shows up as a missing or early `int_pend` bit. A wrong link choice shows up as the next request carrying the wrong destination. A state machine stuck between `S_ISSUE` and `S_WRBK` shows up as a request that never arrives after an event, within about a dozen cycles.

// File: rtl/dma_evt_pkg.sv
package dma_evt_pkg;

    localparam int ENTRY_WORDS = 6;
    localparam int ENTRY_BYTES = ENTRY_WORDS * 4;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_ISSUE, S_WAIT, S_CALC, S_LFETCH, S_WRBK
    } seq_state_t;

    typedef struct packed {
        logic [2:0]  prio;
        logic [1:0]  esize;
        logic        src2d;
        logic [1:0]  smode;
        logic        dst2d;
        logic [1:0]  dmode;
        logic        tcint;
        logic [3:0]  code;
        logic [13:0] rsvd;
        logic        link_en;
        logic        fsync;
    } opt_t;

    localparam logic [1:0] AM_FIXED = 2'd0;
    localparam logic [1:0] AM_INC   = 2'd1;
    localparam logic [1:0] AM_DEC   = 2'd2;
    localparam logic [1:0] AM_IDX   = 2'd3;

    function automatic logic [31:0] next_addr(input logic [31:0] a, input logic [1:0] m,
                                              input logic [31:0] span, input logic [15:0] idx);
        logic [31:0] r;
        unique case (m)
            AM_FIXED: r = a;
            AM_INC:   r = a + span;
            AM_DEC:   r = a - span;
            AM_IDX:   r = a + {{16{idx[15]}}, idx};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dma_evt_latch.sv
module dma_evt_latch #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_in,
    input  logic [N-1:0] pend_clr,
    input  logic [N-1:0] miss_clr,
    output logic [N-1:0] pend,
    output logic [N-1:0] miss
);
    logic [N-1:0] evt_q;

    for (genvar g = 0; g < N; g++) begin : g_ch
        logic rise;
        assign rise = evt_in[g] & ~evt_q[g];
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                evt_q[g] <= 1'b0;
                pend[g]  <= 1'b0;
                miss[g]  <= 1'b0;
            end else begin
                evt_q[g] <= evt_in[g];
                pend[g]  <= (pend[g] & ~pend_clr[g]) | rise;
                miss[g]  <= (miss[g] & ~miss_clr[g]) | (rise & pend[g] & ~pend_clr[g]);
            end
        end
    end
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
    parameter int N  = 16,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          gnt_vld,
    output logic [IW-1:0] gnt_idx
);
    always_comb begin
        gnt_vld = |req;
        gnt_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) gnt_idx = IW'(i);
        end
    end
endmodule

// File: rtl/dma_param_ram.sv
module dma_param_ram #(
    parameter int WORDS = 512,
    localparam int AW = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [31:0]   a_wdata,
    output logic [31:0]   a_rdata,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [31:0]   b_wdata,
    output logic [31:0]   b_rdata
);
    logic [31:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (b_we)      mem[b_addr] <= b_wdata;
        else if (a_we) mem[a_addr] <= a_wdata;
    end

    assign a_rdata = mem[a_addr];
    assign b_rdata = mem[b_addr];
endmodule

// File: rtl/dma_evt_seq.sv
module dma_evt_seq
    import dma_evt_pkg::*;
#(
    parameter int NCH       = 16,
    parameter int RAM_BYTES = 2048,
    localparam int RAM_WORDS = RAM_BYTES / 4,
    localparam int AW        = $clog2(RAM_WORDS),
    localparam int CW        = $clog2(NCH),
    localparam int REGW      = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  evt_in,
    input  logic            cpu_we,
    input  logic [AW-1:0]   cpu_addr,
    input  logic [31:0]     cpu_wdata,
    output logic [31:0]     cpu_rdata,
    input  logic            cpu_reg_we,
    input  logic [1:0]      cpu_reg_sel,
    input  logic [REGW-1:0] cpu_reg_wdata,
    output logic [NCH-1:0]  evt_pend,
    output logic [NCH-1:0]  evt_miss,
    output logic [REGW-1:0] int_pend,
    output logic [REGW-1:0] int_en,
    output logic            irq,
    output logic            link_err,
    output logic            tr_valid,
    input  logic            tr_ready,
    output logic [CW-1:0]   tr_ch,
    output logic [31:0]     tr_opt,
    output logic [31:0]     tr_src,
    output logic [31:0]     tr_dst,
    output logic [15:0]     tr_cnt,
    input  logic            xfer_done
);
    localparam int WCW = $clog2(ENTRY_WORDS);
    localparam logic [WCW-1:0] WC_LAST = WCW'(ENTRY_WORDS - 1);

    seq_state_t      state, state_nx;
    logic [WCW-1:0]  wcnt;
    logic [CW-1:0]   ch;
    logic [AW-1:0]   base;
    logic [31:0]     ent [ENTRY_WORDS];
    logic            gnt_vld;
    logic [CW-1:0]   gnt_idx;
    logic [NCH-1:0]  pend_clr, miss_clr;
    logic [31:0]     eng_rd;
    logic            eng_we;
    logic            last_w;

    // decoded entry and next values
    opt_t        opt;
    logic [15:0] elem, frm, rl, lk;
    logic [1:0]  sh;
    logic        frame_end, blk_done, lk_ok;
    logic [31:0] span, nsrc, ndst;
    logic [15:0] istep, nelem, nfrm;
    logic [REGW-1:0] int_set;

    function automatic logic [AW-1:0] ch_base(input logic [CW-1:0] c);
        return AW'(c) * AW'(ENTRY_WORDS);
    endfunction

    dma_evt_latch #(.N(NCH)) u_latch (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .pend_clr(pend_clr),
        .miss_clr(miss_clr), .pend(evt_pend), .miss(evt_miss)
    );

    dma_prio_pick #(.N(NCH)) u_pick (
        .req(evt_pend), .gnt_vld(gnt_vld), .gnt_idx(gnt_idx)
    );

    dma_param_ram #(.WORDS(RAM_WORDS)) u_ram (
        .clk(clk),
        .a_we(cpu_we), .a_addr(cpu_addr), .a_wdata(cpu_wdata), .a_rdata(cpu_rdata),
        .b_we(eng_we), .b_addr(base + AW'(wcnt)), .b_wdata(ent[wcnt]), .b_rdata(eng_rd)
    );

    always_comb begin
        opt       = opt_t'(ent[0]);
        elem      = ent[2][15:0];
        frm       = ent[2][31:16];
        rl        = ent[5][31:16];
        lk        = ent[5][15:0];
        sh        = (opt.esize == 2'd3) ? 2'd2 : opt.esize;
        frame_end = opt.fsync || (elem == 16'd1);
        blk_done  = frame_end && (frm == 16'd0);
        span      = opt.fsync ? ({16'd0, elem} << sh) : (32'd1 << sh);
        istep     = frame_end ? ent[4][31:16] : ent[4][15:0];
        nsrc      = next_addr(ent[1], opt.smode, span, istep);
        ndst      = next_addr(ent[3], opt.dmode, span, istep);
        nelem     = blk_done ? 16'd0 : (frame_end ? rl : elem - 16'd1);
        nfrm      = blk_done ? 16'd0 : (frame_end ? frm - 16'd1 : frm);
        lk_ok     = (lk % 16'(ENTRY_BYTES) == 16'd0) &&
                    ({1'b0, lk} + 17'(ENTRY_BYTES) <= 17'(RAM_BYTES));
        last_w    = (wcnt == WC_LAST);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (gnt_vld) state_nx = S_FETCH;
            S_FETCH:  if (last_w) state_nx = (elem == 16'd0) ? S_IDLE : S_ISSUE;
            S_ISSUE:  if (tr_ready) state_nx = S_WAIT;
            S_WAIT:   if (xfer_done) state_nx = S_CALC;
            S_CALC:   state_nx = (blk_done && opt.link_en && lk_ok) ? S_LFETCH : S_WRBK;
            S_LFETCH: if (last_w) state_nx = S_WRBK;
            S_WRBK:   if (last_w) state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        tr_valid = (state == S_ISSUE);
        tr_ch    = ch;
        tr_opt   = ent[0];
        tr_src   = ent[1];
        tr_dst   = ent[3];
        tr_cnt   = opt.fsync ? elem : 16'd1;
        eng_we   = (state == S_WRBK);
        pend_clr = '0;
        if (state == S_IDLE && gnt_vld) pend_clr[gnt_idx] = 1'b1;
        if (cpu_reg_we && cpu_reg_sel == 2'd0) pend_clr = pend_clr | cpu_reg_wdata[NCH-1:0];
        miss_clr = (cpu_reg_we && cpu_reg_sel == 2'd1) ? cpu_reg_wdata[NCH-1:0] : '0;
        int_set  = '0;
        if (state == S_CALC && blk_done && opt.tcint) int_set[opt.code] = 1'b1;
        irq      = |(int_pend & int_en);
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt     <= '0;
            ch       <= '0;
            base     <= '0;
            link_err <= 1'b0;
            int_pend <= '0;
            int_en   <= '0;
            for (int i = 0; i < ENTRY_WORDS; i++) ent[i] <= '0;
        end else begin
            if (cpu_reg_we && cpu_reg_sel == 2'd3) int_en <= cpu_reg_wdata;
            int_pend <= (int_pend & ~((cpu_reg_we && cpu_reg_sel == 2'd2) ? cpu_reg_wdata : '0))
                        | int_set;
            unique case (state)
                S_IDLE: if (gnt_vld) begin
                    ch   <= gnt_idx;
                    base <= ch_base(gnt_idx);
                    wcnt <= '0;
                end
                S_FETCH, S_LFETCH: begin
                    ent[wcnt] <= eng_rd;
                    wcnt      <= last_w ? '0 : wcnt + 1'b1;
                    if (state == S_LFETCH && last_w) base <= ch_base(ch);
                end
                S_CALC: begin
                    ent[1] <= nsrc;
                    ent[2] <= {nfrm, nelem};
                    ent[3] <= ndst;
                    wcnt   <= '0;
                    if (blk_done && opt.link_en) begin
                        if (lk_ok) base <= AW'(lk >> 2);
                        else       link_err <= 1'b1;
                    end
                end
                S_WRBK: wcnt <= last_w ? '0 : wcnt + 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dma_evt_seq_chk.sv
module dma_evt_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tr_valid,
    input logic        tr_ready,
    input logic [31:0] tr_src,
    input logic [31:0] tr_dst,
    input logic [15:0] tr_cnt,
    input logic        xfer_done,
    input logic [15:0] int_pend,
    input logic [15:0] evt_pend,
    input logic [15:0] evt_miss,
    input logic        link_err
);
    assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (tr_valid && !tr_ready) |=> (tr_valid && $stable(tr_src) && $stable(tr_dst) && $stable(tr_cnt)));

    assert_req_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tr_valid |-> (tr_cnt != 16'd0));

    assert_int_after_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((int_pend & ~$past(int_pend)) != 16'd0) |-> $past(xfer_done, 2));

    assert_miss_needs_pend_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_miss & ~$past(evt_miss) & ~$past(evt_pend)) == 16'd0));

    assert_link_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(link_err));
endmodule

bind dma_evt_seq dma_evt_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tr_valid(tr_valid), .tr_ready(tr_ready),
    .tr_src(tr_src), .tr_dst(tr_dst), .tr_cnt(tr_cnt), .xfer_done(xfer_done),
    .int_pend(int_pend), .evt_pend(evt_pend), .evt_miss(evt_miss), .link_err(link_err)
);

// File: tb/dma_evt_seq_test.sv
`timescale 1ns/1ps
module dma_evt_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] evt_in = '0;
    logic        cpu_we = 1'b0;
    logic [8:0]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_reg_we = 1'b0;
    logic [1:0]  cpu_reg_sel = '0;
    logic [15:0] cpu_reg_wdata = '0;
    logic [15:0] evt_pend, evt_miss, int_pend, int_en;
    logic        irq, link_err, tr_valid;
    logic        tr_ready = 1'b0;
    logic [3:0]  tr_ch;
    logic [31:0] tr_opt, tr_src, tr_dst;
    logic [15:0] tr_cnt;
    logic        xfer_done = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dma_evt_seq uut (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_reg_we(cpu_reg_we),
        .cpu_reg_sel(cpu_reg_sel), .cpu_reg_wdata(cpu_reg_wdata), .evt_pend(evt_pend),
        .evt_miss(evt_miss), .int_pend(int_pend), .int_en(int_en), .irq(irq),
        .link_err(link_err), .tr_valid(tr_valid), .tr_ready(tr_ready), .tr_ch(tr_ch),
        .tr_opt(tr_opt), .tr_src(tr_src), .tr_dst(tr_dst), .tr_cnt(tr_cnt),
        .xfer_done(xfer_done)
    );

    // element-sync walk on channel 2: expected source / destination per event
    localparam logic [31:0] ES_SRC [6] = '{32'h1000, 32'h1004, 32'h1008, 32'h100C, 32'h1010, 32'h1014};
    localparam logic [31:0] ES_DST [6] = '{32'h2000, 32'h2008, 32'h2010, 32'h2050, 32'h2058, 32'h2060};
    // ping-pong destinations on channel 0
    localparam logic [31:0] PP_DST [4] = '{32'h5000, 32'h6000, 32'h7000, 32'h6000};

    function automatic logic [31:0] mkopt(input logic [2:0] pr, input logic [1:0] es,
        input logic [1:0] sm, input logic [1:0] dm, input logic ti, input logic [3:0] cd,
        input logic ln, input logic fs);
        return {pr, es, 1'b0, sm, 1'b0, dm, ti, cd, 14'd0, ln, fs};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic ram_wr(input int a, input logic [31:0] d);
        @(negedge clk); cpu_we = 1'b1; cpu_addr = 9'(a); cpu_wdata = d;
        @(negedge clk); cpu_we = 1'b0;
    endtask

    task automatic ram_rd(input int a, output logic [31:0] d);
        @(negedge clk); cpu_addr = 9'(a); #1; d = cpu_rdata;
    endtask

    task automatic wr_entry(input int b, input logic [31:0] w0, input logic [31:0] w1,
        input logic [31:0] w2, input logic [31:0] w3, input logic [31:0] w4, input logic [31:0] w5);
        ram_wr(b, w0); ram_wr(b + 1, w1); ram_wr(b + 2, w2);
        ram_wr(b + 3, w3); ram_wr(b + 4, w4); ram_wr(b + 5, w5);
    endtask

    task automatic reg_wr(input logic [1:0] s, input logic [15:0] d);
        @(negedge clk); cpu_reg_we = 1'b1; cpu_reg_sel = s; cpu_reg_wdata = d;
        @(negedge clk); cpu_reg_we = 1'b0;
    endtask

    task automatic pulse(input logic [15:0] m);
        @(negedge clk); evt_in = m;
        @(negedge clk); evt_in = '0;
    endtask

    task automatic wait_req(input string req);
        bit got = 1'b0;
        for (int i = 0; i < 60 && !got; i++) begin
            @(negedge clk);
            got = tr_valid;
        end
        chk(got, req, 32'(got), 32'd1);
    endtask

    task automatic no_req(input string req, input int cyc);
        bit seen = 1'b0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (tr_valid) seen = 1'b1;
        end
        chk(!seen, req, 32'(seen), 32'd0);
    endtask

    task automatic accept();
        @(negedge clk); tr_ready = 1'b1;
        @(negedge clk); tr_ready = 1'b0;
    endtask

    task automatic finish_xfer();
        @(negedge clk); xfer_done = 1'b1;
        @(negedge clk); xfer_done = 1'b0;
        repeat (20) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk(tr_valid == 1'b0, "R13 reset tr_valid", 32'(tr_valid), 32'd0);
        chk(irq == 1'b0 && int_pend == 16'd0, "R12 reset irq", {16'(irq), int_pend}, 32'd0);
        chk(evt_pend == 16'd0 && evt_miss == 16'd0, "R1 reset pend", {evt_pend, evt_miss}, 32'd0);
        chk(link_err == 1'b0, "R10 reset link_err", 32'(link_err), 32'd0);

        // channel 2: element sync, word size, src step, dst indexed, code 5
        wr_entry(12, mkopt(3'd0, 2'd2, 2'd1, 2'd3, 1'b1, 4'd5, 1'b0, 1'b0),
                 32'h1000, {16'd1, 16'd3}, 32'h2000, {16'h0040, 16'h0008}, {16'd3, 16'd0});
        reg_wr(2'd3, 16'h0020);
        for (int i = 0; i < 6; i++) begin
            pulse(16'h0004);
            wait_req("R4 element-sync request");
            chk(tr_src == ES_SRC[i], "R5 source address", tr_src, ES_SRC[i]);
            chk(tr_dst == ES_DST[i], "R6 destination address", tr_dst, ES_DST[i]);
            chk(tr_cnt == 16'd1 && tr_ch == 4'd2, "R6 count and channel", {tr_cnt, 12'd0, tr_ch}, {16'd1, 16'd2});
            if (i == 0) begin
                repeat (3) @(negedge clk);
                chk(tr_valid && tr_src == ES_SRC[0], "R13 request held", tr_src, ES_SRC[0]);
            end
            accept();
            repeat (3) @(negedge clk);
            chk(int_pend == 16'd0, "R11 no interrupt before done", 32'(int_pend), 32'd0);
            finish_xfer();
        end
        chk(int_pend == 16'h0020, "R11 code 5 pending", 32'(int_pend), 32'h20);
        chk(irq == 1'b1, "R12 irq with enable", 32'(irq), 32'd1);
        ram_rd(14, rd);
        chk(rd == 32'd0, "R8 counts zeroed", rd, 32'd0);
        pulse(16'h0004);
        no_req("R8 finished channel silent", 30);
        chk(evt_pend[2] == 1'b0, "R1 pend consumed", 32'(evt_pend), 32'd0);
        reg_wr(2'd2, 16'h0020);
        chk(int_pend == 16'd0 && irq == 1'b0, "R12 interrupt cleared", {16'(irq), int_pend}, 32'd0);

        // priority and missed events on channels 1 and 3
        wr_entry(6, mkopt(3'd0, 2'd2, 2'd1, 2'd1, 1'b0, 4'd0, 1'b0, 1'b1),
                 32'h100, {16'd0, 16'd2}, 32'h200, 32'd0, {16'd2, 16'd0});
        wr_entry(18, mkopt(3'd0, 2'd2, 2'd1, 2'd1, 1'b0, 4'd0, 1'b0, 1'b1),
                 32'h300, {16'd0, 16'd2}, 32'h400, 32'd0, {16'd2, 16'd0});
        pulse(16'h000A);
        wait_req("R3 request");
        chk(tr_ch == 4'd1, "R3 lowest channel first", 32'(tr_ch), 32'd1);
        chk(tr_cnt == 16'd2, "R7 frame-sync count", 32'(tr_cnt), 32'd2);
        chk(evt_pend[3] == 1'b1, "R1 channel 3 still pending", 32'(evt_pend), 32'h8);
        pulse(16'h0008);
        chk(evt_miss == 16'h0008, "R2 missed event", 32'(evt_miss), 32'h8);
        reg_wr(2'd0, 16'h0008);
        chk(evt_pend == 16'd0, "R1 pending cleared by write", 32'(evt_pend), 32'd0);
        accept();
        finish_xfer();
        no_req("R1 cleared channel not serviced", 30);
        reg_wr(2'd1, 16'h0008);
        chk(evt_miss == 16'd0, "R2 missed cleared", 32'(evt_miss), 32'd0);

        // ping-pong linking on channel 0, priority 1, half words, code 5
        wr_entry(0, mkopt(3'd1, 2'd1, 2'd0, 2'd1, 1'b1, 4'd5, 1'b1, 1'b1),
                 32'h40, {16'd0, 16'd4}, 32'h5000, 32'd0, {16'd4, 16'd384});
        wr_entry(96, mkopt(3'd1, 2'd1, 2'd0, 2'd1, 1'b1, 4'd5, 1'b1, 1'b1),
                 32'h40, {16'd0, 16'd4}, 32'h6000, 32'd0, {16'd4, 16'd408});
        wr_entry(102, mkopt(3'd1, 2'd1, 2'd0, 2'd1, 1'b1, 4'd5, 1'b1, 1'b1),
                 32'h40, {16'd0, 16'd4}, 32'h7000, 32'd0, {16'd4, 16'd384});
        for (int i = 0; i < 4; i++) begin
            pulse(16'h0001);
            wait_req("R9 linked request");
            chk(tr_dst == PP_DST[i], "R9 ping-pong destination", tr_dst, PP_DST[i]);
            chk(tr_opt[31:29] == 3'd1 && tr_cnt == 16'd4, "R4 options and count",
                {13'd0, tr_opt[31:29], tr_cnt}, {16'd1, 16'd4});
            accept();
            finish_xfer();
            if (i == 0) begin
                ram_rd(3, rd);
                chk(rd == 32'h6000, "R9 entry replaced dst", rd, 32'h6000);
                ram_rd(5, rd);
                chk(rd == {16'd4, 16'd408}, "R9 entry replaced link", rd, {16'd4, 16'd408});
                chk(int_pend == 16'h0020, "R11 shared code", 32'(int_pend), 32'h20);
                reg_wr(2'd3, 16'h0000);
                chk(irq == 1'b0, "R12 disabled pending", 32'(irq), 32'd0);
            end
        end

        // channel 6: frame sync, src stepping back, bad link address 100
        wr_entry(36, mkopt(3'd0, 2'd2, 2'd2, 2'd1, 1'b0, 4'd0, 1'b1, 1'b1),
                 32'h800, {16'd1, 16'd2}, 32'h900, 32'd0, {16'd2, 16'd100});
        pulse(16'h0040);
        wait_req("R7 request");
        chk(tr_src == 32'h800, "R4 source word", tr_src, 32'h800);
        accept();
        finish_xfer();
        ram_rd(37, rd);
        chk(rd == 32'h7F8, "R5 source steps back", rd, 32'h7F8);
        ram_rd(39, rd);
        chk(rd == 32'h908, "R7 destination by frame", rd, 32'h908);
        ram_rd(38, rd);
        chk(rd == {16'd0, 16'd2}, "R7 counts reloaded", rd, {16'd0, 16'd2});
        chk(link_err == 1'b0, "R10 no error mid-block", 32'(link_err), 32'd0);
        pulse(16'h0040);
        wait_req("R10 request");
        chk(tr_src == 32'h7F8, "R5 second source", tr_src, 32'h7F8);
        accept();
        finish_xfer();
        chk(link_err == 1'b1, "R10 bad link flagged", 32'(link_err), 32'd1);
        ram_rd(41, rd);
        chk(rd == {16'd2, 16'd100}, "R10 entry not replaced", rd, {16'd2, 16'd100});
        ram_rd(38, rd);
        chk(rd == 32'd0, "R8 counts zero after block", rd, 32'd0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule